// File: doc/BRIEF.md
# PRBS Test Pattern Generator

This block emits an endless stream of test symbols on a streaming source port guarded by valid/ready handshaking. It is meant to drive a link, a loopback path or a receiving checker during bring-up. A small register port lets software start and stop the stream and choose one of six patterns. Four are pseudo-random sequences from linear feedback shift registers. The other two are fixed symbols, one toggling at the highest rate and one at a low rate.

An optional preamble can be sent first. When it is enabled, a programmable word is repeated for a programmable number of accepted beats after each start, and only then does the selected pattern begin. Software can also ask for one corrupted bit. The symbol width is a parameter and may be 8 or 10 bits.

Top module: `prbs_gen`

## Requirements
- R1: After reset, `src_valid_o` is low and every readable register returns zero: pattern code 0, preamble disabled, preamble word 0 and beat count 0.
- R2: Writing address 0 with bit 0 set starts the generator when it is idle. `src_valid_o` is high from the next cycle, and address 0 then reads bit 0 as 1. Writing address 0 with bit 0 clear stops it, and `src_valid_o` is low from the next cycle.
- R3: Pattern codes 0, 1, 2 and 3 select the sequences of x^7+x^6+1, x^15+x^14+1, x^23+x^18+1 and x^31+x^28+1. Each register is loaded with all ones at every start. One serial step computes feedback as the XOR of the two tapped stages, shifts it in at the low end, and outputs it. A symbol holds SYM_W successive feedback bits, with the first one in the MSB.
- R4: Pattern code 4 sends the alternating symbol 0x2AA on every beat for 10-bit symbols, or 0xAA for 8-bit symbols.
- R5: Pattern code 5 sends 0x3E0 on every beat for 10-bit symbols, or 0xF0 for 8-bit symbols.
- R6: While `src_ready_i` is low, the symbol on `src_data_o` holds and the sequence does not advance. Each accepted beat (valid and ready both high) advances the sequence by exactly one symbol.
- R7: Bit 1 of address 0 enables the preamble. Address 2 holds the preamble word and address 3 holds the beat count. With the preamble enabled and a count N of at least 1, the first N accepted beats after a start carry the word, and the pattern then starts from its seed. With N = 0, the pattern starts at once.
- R8: Any write to address 4 inverts bit 0 of the next accepted beat only. The inversion is visible while that beat waits for ready, and the beat after it is unaltered.
- R9: Addresses 1, 2 and 3 read back the last value written to them, and bit 1 of address 0 reads back the preamble enable.
- R10: A new pattern code written while the generator runs is stored and readable, but the output keeps the pattern latched at start until the next stop and start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational on address |
| src_valid_o | output | 1 | Symbol valid, high while running |
| src_ready_i | input | 1 | Sink ready |
| src_data_o | output | SYM_W | Output symbol |

## Verification
The assertions rely on a few properties of the inputs. A start and a stop never arrive in the same write. No register write lands in a cycle where the output must hold still. The reset is released away from a clock edge. The bench keeps to this by changing all inputs on falling edges and by issuing only single-address writes. It holds ready low around any write whose effect must be seen on a stalled beat. Every sequence is compared against a serial model built from the stated polynomials.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;
  localparam int NUM_LFSR = 4;
  localparam int PAT_W    = 3;

  typedef enum logic [PAT_W-1:0] {
    PAT_PRBS7  = 3'd0,
    PAT_PRBS15 = 3'd1,
    PAT_PRBS23 = 3'd2,
    PAT_PRBS31 = 3'd3,
    PAT_HF     = 3'd4,
    PAT_LF     = 3'd5
  } pat_e;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_PAT    = 3'd1,
    REG_PWORD  = 3'd2,
    REG_PBEATS = 3'd3,
    REG_INJ    = 3'd4
  } reg_sel_e;

  function automatic int lfsr_len(int idx);
    case (idx)
      0:       return 7;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int lfsr_tap(int idx);
    case (idx)
      0:       return 6;
      1:       return 14;
      2:       return 18;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
  parameter int LEN   = 7,
  parameter int TAP   = 6,
  parameter int SYM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_i,
  input  logic             adv_i,
  output logic [SYM_W-1:0] sym_o
);
  logic [LEN-1:0] state_q, state_nxt;

  // unroll SYM_W serial steps per beat
  always_comb begin
    logic [LEN-1:0] s;
    logic fb;
    s = state_q;
    sym_o = '0;
    for (int k = 0; k < SYM_W; k++) begin
      fb = s[LEN-1] ^ s[TAP-1];
      sym_o[SYM_W-1-k] = fb;
      s = {s[LEN-2:0], fb};
    end
    state_nxt = s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '1;
    else if (seed_i) state_q <= '1;
    else if (adv_i)  state_q <= state_nxt;
  end

  a_r3_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

  a_r6_lfsr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !seed_i |=> $stable(state_q));
endmodule

// File: rtl/prbs_lfsr_bank.sv
module prbs_lfsr_bank
  import prbs_gen_pkg::*;
#(
  parameter int SYM_W = 10
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           seed_i,
  input  logic                           adv_i,
  output logic [NUM_LFSR-1:0][SYM_W-1:0] sym_o
);
  for (genvar g = 0; g < NUM_LFSR; g++) begin : g_lfsr
    localparam int LEN = lfsr_len(g);
    localparam int TAP = lfsr_tap(g);
    prbs_lfsr #(.LEN(LEN), .TAP(TAP), .SYM_W(SYM_W)) u_lfsr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .seed_i (seed_i),
      .adv_i  (adv_i),
      .sym_o  (sym_o[g])
    );
  end
endmodule

// File: rtl/prbs_gen_regs.sv
module prbs_gen_regs
  import prbs_gen_pkg::*;
#(
  parameter int SYM_W   = 10,
  parameter int BEATS_W = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               running_i,
  output logic               start_o,
  output logic               stop_o,
  output logic               inject_o,
  output logic [PAT_W-1:0]   pat_o,
  output logic               pre_en_o,
  output logic [SYM_W-1:0]   pre_word_o,
  output logic [BEATS_W-1:0] pre_beats_o
);
  logic               pre_en_q;
  logic [PAT_W-1:0]   pat_q;
  logic [SYM_W-1:0]   word_q;
  logic [BEATS_W-1:0] beats_q;
  logic               ctrl_wr;

  assign ctrl_wr  = we_i && (addr_i == ADDR_W'(REG_CTRL));
  assign start_o  = ctrl_wr && wdata_i[0] && !running_i;
  assign stop_o   = ctrl_wr && !wdata_i[0] && running_i;
  assign inject_o = we_i && (addr_i == ADDR_W'(REG_INJ));
  // a start in the same write sees the new enable
  assign pre_en_o    = ctrl_wr ? wdata_i[1] : pre_en_q;
  assign pat_o       = pat_q;
  assign pre_word_o  = word_q;
  assign pre_beats_o = beats_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_en_q <= 1'b0;
      pat_q    <= '0;
      word_q   <= '0;
      beats_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_W'(REG_CTRL):   pre_en_q <= wdata_i[1];
        ADDR_W'(REG_PAT):    pat_q    <= wdata_i[PAT_W-1:0];
        ADDR_W'(REG_PWORD):  word_q   <= wdata_i[SYM_W-1:0];
        ADDR_W'(REG_PBEATS): beats_q  <= wdata_i[BEATS_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(REG_CTRL):   rdata_o[1:0] = {pre_en_q, running_i};
      ADDR_W'(REG_PAT):    rdata_o[PAT_W-1:0] = pat_q;
      ADDR_W'(REG_PWORD):  rdata_o[SYM_W-1:0] = word_q;
      ADDR_W'(REG_PBEATS): rdata_o[BEATS_W-1:0] = beats_q;
      default: ;
    endcase
  end

  a_r9_pat_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_W'(REG_PAT) |=> pat_o == $past(wdata_i[PAT_W-1:0]));
endmodule

// File: rtl/prbs_gen_seq.sv
module prbs_gen_seq
  import prbs_gen_pkg::*;
#(
  parameter int SYM_W   = 10,
  parameter int BEATS_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           stop_i,
  input  logic                           inject_i,
  input  logic [PAT_W-1:0]               pat_i,
  input  logic                           pre_en_i,
  input  logic [SYM_W-1:0]               pre_word_i,
  input  logic [BEATS_W-1:0]             pre_beats_i,
  input  logic [NUM_LFSR-1:0][SYM_W-1:0] lfsr_sym_i,
  output logic                           seed_o,
  output logic                           adv_o,
  output logic                           running_o,
  output logic                           valid_o,
  input  logic                           ready_i,
  output logic [SYM_W-1:0]               data_o
);
  localparam int HALF = SYM_W / 2;

  function automatic logic [SYM_W-1:0] hf_sym();
    logic [SYM_W-1:0] v;
    for (int i = 0; i < SYM_W; i++) v[i] = (i % 2) == 1;
    return v;
  endfunction

  function automatic logic [SYM_W-1:0] lf_sym();
    logic [SYM_W-1:0] v;
    for (int i = 0; i < SYM_W; i++) v[i] = i >= HALF;
    return v;
  endfunction

  localparam logic [SYM_W-1:0] HF_SYM = hf_sym();
  localparam logic [SYM_W-1:0] LF_SYM = lf_sym();

  logic               running_q, in_pre_q, err_q;
  logic [PAT_W-1:0]   act_pat_q;
  logic [BEATS_W-1:0] pre_cnt_q;
  logic               accept;
  logic [SYM_W-1:0]   raw;

  assign accept    = running_q && ready_i;
  assign seed_o    = start_i;
  assign adv_o     = accept && !in_pre_q;
  assign running_o = running_q;
  assign valid_o   = running_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      in_pre_q  <= 1'b0;
      act_pat_q <= '0;
      pre_cnt_q <= '0;
    end else if (start_i) begin
      running_q <= 1'b1;
      act_pat_q <= pat_i;
      in_pre_q  <= pre_en_i && (pre_beats_i != '0);
      pre_cnt_q <= pre_beats_i;
    end else if (stop_i) begin
      running_q <= 1'b0;
      in_pre_q  <= 1'b0;
    end else if (accept && in_pre_q) begin
      pre_cnt_q <= pre_cnt_q - 1'b1;
      if (pre_cnt_q == BEATS_W'(1)) in_pre_q <= 1'b0;
    end
  end

  // a new request wins over a beat accepted in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= 1'b0;
    else if (inject_i) err_q <= 1'b1;
    else if (accept)   err_q <= 1'b0;
  end

  always_comb begin
    raw = '0;
    if (in_pre_q) raw = pre_word_i;
    else begin
      case (act_pat_q)
        PAT_PRBS7:  raw = lfsr_sym_i[0];
        PAT_PRBS15: raw = lfsr_sym_i[1];
        PAT_PRBS23: raw = lfsr_sym_i[2];
        PAT_PRBS31: raw = lfsr_sym_i[3];
        PAT_HF:     raw = HF_SYM;
        PAT_LF:     raw = LF_SYM;
        default:    raw = '0;
      endcase
    end
  end

  assign data_o = raw ^ {{(SYM_W-1){1'b0}}, err_q};

  a_r2_start_raises_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  a_r2_stop_drops_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !valid_o);

  a_r6_stall_holds_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !stop_i && !inject_i |=> $stable(data_o));

  a_r8_flip_one_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && accept && !inject_i |=> !err_q);

  a_r7_preamble_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pre_q && accept && !start_i && !stop_i |=> pre_cnt_q == $past(pre_cnt_q) - 1'b1);

  a_r10_pattern_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(act_pat_q));
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_gen_pkg::*;
#(
  parameter int SYM_W   = 10,
  parameter int BEATS_W = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              src_valid_o,
  input  logic              src_ready_i,
  output logic [SYM_W-1:0]  src_data_o
);
  logic                           start, stop, inject, pre_en, running, seed, adv;
  logic [PAT_W-1:0]               pat;
  logic [SYM_W-1:0]               pre_word;
  logic [BEATS_W-1:0]             pre_beats;
  logic [NUM_LFSR-1:0][SYM_W-1:0] lfsr_sym;

  prbs_gen_regs #(.SYM_W(SYM_W), .BEATS_W(BEATS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .running_i   (running),
    .start_o     (start),
    .stop_o      (stop),
    .inject_o    (inject),
    .pat_o       (pat),
    .pre_en_o    (pre_en),
    .pre_word_o  (pre_word),
    .pre_beats_o (pre_beats)
  );

  prbs_lfsr_bank #(.SYM_W(SYM_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (seed),
    .adv_i  (adv),
    .sym_o  (lfsr_sym)
  );

  prbs_gen_seq #(.SYM_W(SYM_W), .BEATS_W(BEATS_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .stop_i      (stop),
    .inject_i    (inject),
    .pat_i       (pat),
    .pre_en_i    (pre_en),
    .pre_word_i  (pre_word),
    .pre_beats_i (pre_beats),
    .lfsr_sym_i  (lfsr_sym),
    .seed_o      (seed),
    .adv_o       (adv),
    .running_o   (running),
    .valid_o     (src_valid_o),
    .ready_i     (src_ready_i),
    .data_o      (src_data_o)
  );
endmodule

// File: tb/tb_prbs_gen.sv
module tb_prbs_gen;
  localparam int CLK_PERIOD = 10;
  localparam int SYM_W = 10;
  localparam logic [9:0] HF_EXP = 10'h2AA;
  localparam logic [9:0] LF_EXP = 10'h3E0;

  typedef struct packed {
    logic [2:0] code;
    logic [5:0] len;  // 0: fixed pattern
    logic [5:0] tap;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 6'd7,  6'd6},
    '{3'd1, 6'd15, 6'd14},
    '{3'd2, 6'd23, 6'd18},
    '{3'd3, 6'd31, 6'd28},
    '{3'd4, 6'd0,  6'd0},
    '{3'd5, 6'd0,  6'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, ready = 1'b1;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        valid;
  logic [SYM_W-1:0] data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] ref_s;
  int ref_len, ref_tap;

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_valid_o(valid),
    .src_ready_i(ready), .src_data_o(data)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ref_seed(int len, int tap);
    ref_len = len; ref_tap = tap; ref_s = '1;
  endtask

  // serial reference: feedback = xor of taps, shifted in, first bit to MSB
  task automatic ref_next(output logic [SYM_W-1:0] sym);
    logic fb;
    logic [31:0] mask;
    mask = (ref_len == 32) ? '1 : ((32'h1 << ref_len) - 1);
    ref_s = ref_s & mask;
    for (int k = 0; k < SYM_W; k++) begin
      fb = ref_s[ref_len-1] ^ ref_s[ref_tap-1];
      sym[SYM_W-1-k] = fb;
      ref_s = ((ref_s << 1) | 32'(fb)) & mask;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [SYM_W-1:0] e, e1;
    #(CLK_PERIOD * 2 + 3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 valid", 32'(valid), 0);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), r);
      check("R1 reg", r, 0);
    end

    // table walk: R3 R4 R5
    foreach (VECS[i]) begin
      wr(3'd1, 32'(VECS[i].code));
      wr(3'd0, 32'h1);
      if (i == 0) begin
        check("R2 valid after start", 32'(valid), 1);
        rd(3'd0, r);
        check("R2 running bit", r, 1);
      end
      ref_seed(VECS[i].len, VECS[i].tap);
      for (int b = 0; b < 4; b++) begin
        if (VECS[i].len != 0) ref_next(e);
        else e = (VECS[i].code == 3'd4) ? HF_EXP : LF_EXP;
        check(VECS[i].len != 0 ? "R3 prbs" : (VECS[i].code == 3'd4 ? "R4 hf" : "R5 lf"),
              32'(data), 32'(e));
        @(negedge clk);
      end
      wr(3'd0, 32'h0);
      if (i == 0) check("R2 valid after stop", 32'(valid), 0);
    end

    // R6 stall holds data, then one accepted beat advances one symbol
    wr(3'd1, 32'd1);
    ready = 1'b0;
    wr(3'd0, 32'h1);
    ref_seed(15, 14);
    ref_next(e);
    for (int s = 0; s < 3; s++) begin
      check("R6 hold", 32'(data), 32'(e));
      @(negedge clk);
    end
    ready = 1'b1;
    @(negedge clk);
    ref_next(e1);
    check("R6 advance", 32'(data), 32'(e1));

    // R8 single-bit inject on a stalled beat
    ready = 1'b0;
    wr(3'd4, 32'h0);
    check("R8 flipped", 32'(data), 32'(e1 ^ 10'h1));
    ready = 1'b1;
    @(negedge clk);
    ref_next(e);
    check("R8 next clean", 32'(data), 32'(e));
    wr(3'd0, 32'h0);

    // R7 preamble then pattern from seed; R9 readback
    wr(3'd2, 32'h155);
    wr(3'd3, 32'd3);
    wr(3'd1, 32'd0);
    wr(3'd0, 32'h3);
    for (int b = 0; b < 3; b++) begin
      check("R7 preamble", 32'(data), 32'h155);
      @(negedge clk);
    end
    ref_seed(7, 6);
    ref_next(e);
    check("R7 pattern after preamble", 32'(data), 32'(e));
    rd(3'd0, r); check("R9 ctrl", r, 32'h3);
    rd(3'd2, r); check("R9 word", r, 32'h155);
    rd(3'd3, r); check("R9 beats", r, 32'd3);
    wr(3'd0, 32'h2);
    rd(3'd0, r); check("R9 enable kept", r, 32'h2);

    // R7 zero beats: no preamble
    wr(3'd3, 32'd0);
    wr(3'd0, 32'h3);
    ref_seed(7, 6);
    ref_next(e);
    check("R7 zero beats", 32'(data), 32'(e));
    wr(3'd0, 32'h0);

    // R10 pattern change while running
    wr(3'd1, 32'd4);
    wr(3'd0, 32'h1);
    wr(3'd1, 32'd5);
    check("R10 still hf", 32'(data), 32'(HF_EXP));
    rd(3'd1, r); check("R10 stored", r, 32'd5);
    wr(3'd0, 32'h0);
    wr(3'd0, 32'h1);
    check("R10 lf after restart", 32'(data), 32'(LF_EXP));
    wr(3'd0, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule